// File: doc/BRIEF.md
# Request/Grant Handshake Timing Monitor

This block watches a single-bit request line and a single-bit grant line on one clock and judges each handshake. After request rises, grant must rise a fixed number of clocks later (three by default). Grant must then stay high for the same number of clocks that request stayed high. The monitor measures both pulses with saturating counters. It compares the widths once both pulses have fallen, and emits a one-cycle pass or width-error strobe for each handshake. Timing faults on the grant rising edge produce a one-cycle delay-error strobe.

The two pulses may overlap. Request may still be high when grant rises, and may even outlast grant. The request width is latched when request falls, and the decision waits until both lines are low. A request rising edge that arrives while a handshake is still open is not tracked. It sets a sticky overlap flag instead. All state is cleared by a synchronous active-high reset. `DELAY` must be at least 1.

Top module: `rg_handshake_mon`

## Requirements
- R1: A grant rising edge that comes exactly `DELAY` clocks after an accepted request rising edge raises no delay error. A grant rising edge that comes earlier raises one delay-error strobe and abandons the handshake.
- R2: If grant has not risen by the `DELAY`-th clock after the request rising edge, a delay-error strobe is raised at that clock and the handshake is abandoned.
- R3: A grant rising edge outside the post-request wait window raises a delay-error strobe. This covers the idle state and the case where grant rises again while request is still high.
- R4: When the grant width equals the request width, a single `pass_o` strobe is raised. It comes in the cycle after the sample at which the later of the two falling edges is seen.
- R5: When the two widths differ, a single `width_err_o` strobe is raised at the same point instead of `pass_o`.
- R6: Overlapping pulses are judged correctly. This holds when request is still high as grant rises, and when request is still high as grant falls; in the second case the decision waits for request to fall.
- R7: A request rising edge that arrives while a handshake is open does not change that handshake's result. It sets `overlap_seen_o`, which stays set until reset.
- R8: Width counters saturate at 2^`CNT_W`-1 (255 by default). Two pulses that are both at least that long compare equal.
- R9: Reset clears all outputs and abandons any open handshake.
- R10: `pass_o` and `width_err_o` are each high for one cycle per decision, never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Observed request line |
| gnt_i | input | 1 | Observed grant line |
| pass_o | output | 1 | One-cycle strobe: handshake met delay and width rules |
| width_err_o | output | 1 | One-cycle strobe: grant width differs from request width |
| delay_err_o | output | 1 | One-cycle strobe: grant rising edge early, late or stray |
| overlap_seen_o | output | 1 | Sticky: a request rose while a handshake was open |

## Verification
Every combination of request width 1 to 6, grant width 1 to 6 and grant offset 1 to 5 clocks is swept. The offset separates early, on-time and late grants, and the width pairs separate equal from unequal pulses. The long-request cases with a short grant force the path where the decision waits for request to fall. Directed runs cover counter saturation (300 versus 300, and 254 versus 255), a second request inside an open handshake, and a reset that lands mid-handshake followed by a stray grant.

// File: rtl/rg_mon_pkg.sv
package rg_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT_G = 2'd1,
    ST_MEAS   = 2'd2,
    ST_WAIT_R = 2'd3
  } mon_st_t;
endpackage

// File: rtl/rg_edge_det.sv
module rg_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/rg_pulse_cnt.sv
module rg_pulse_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Holds the number of high samples seen since the last rising edge.
  always_ff @(posedge clk) begin
    if (rst)                          cnt_o <= '0;
    else if (rise_i)                  cnt_o <= CNT_W'(1);
    else if (sig_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/rg_handshake_mon.sv
module rg_handshake_mon
  import rg_mon_pkg::*;
#(
  parameter int DELAY = 3,
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic gnt_i,
  output logic pass_o,
  output logic width_err_o,
  output logic delay_err_o,
  output logic overlap_seen_o
);
  localparam int NSIG = 2;
  localparam int DW   = $clog2(DELAY + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(DELAY);

  logic [NSIG-1:0] sig_v, rise_v, fall_v;
  logic [CNT_W-1:0] cnt_v [NSIG];

  assign sig_v = {gnt_i, req_i};

  for (genvar i = 0; i < NSIG; i++) begin : g_line
    rg_edge_det u_edge (
      .clk(clk), .rst(rst), .sig_i(sig_v[i]),
      .rise_o(rise_v[i]), .fall_o(fall_v[i])
    );
    rg_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .sig_i(sig_v[i]),
      .rise_i(rise_v[i]), .cnt_o(cnt_v[i])
    );
  end

  logic req_rise, req_fall, gnt_rise, gnt_fall;
  assign req_rise = rise_v[0];
  assign req_fall = fall_v[0];
  assign gnt_rise = rise_v[1];
  assign gnt_fall = fall_v[1];

  mon_st_t          st;
  logic [DW-1:0]    dly;
  logic             req_trk;
  logic [CNT_W-1:0] req_len, gnt_len;

  // Request width as known at this sample, and whether it has ended.
  logic [CNT_W-1:0] req_len_now;
  logic             req_ended;
  assign req_len_now = (req_fall && req_trk) ? cnt_v[0] : req_len;
  assign req_ended   = !req_trk || req_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      dly            <= '0;
      req_trk        <= 1'b0;
      req_len        <= '0;
      gnt_len        <= '0;
      pass_o         <= 1'b0;
      width_err_o    <= 1'b0;
      delay_err_o    <= 1'b0;
      overlap_seen_o <= 1'b0;
    end else begin
      pass_o      <= 1'b0;
      width_err_o <= 1'b0;
      delay_err_o <= 1'b0;

      if (req_fall && req_trk) begin
        req_len <= cnt_v[0];
        req_trk <= 1'b0;
      end
      if (req_rise && st != ST_IDLE) overlap_seen_o <= 1'b1;
      if (gnt_rise && st != ST_WAIT_G) delay_err_o <= 1'b1;

      case (st)
        ST_IDLE: begin
          if (req_rise) begin
            st      <= ST_WAIT_G;
            dly     <= DW'(1);
            req_trk <= 1'b1;
          end
        end
        ST_WAIT_G: begin
          if (gnt_rise) begin
            if (dly == DLY_LAST) begin
              st <= ST_MEAS;
            end else begin
              delay_err_o <= 1'b1;
              st          <= ST_IDLE;
              req_trk     <= 1'b0;
            end
          end else if (dly == DLY_LAST) begin
            delay_err_o <= 1'b1;
            st          <= ST_IDLE;
            req_trk     <= 1'b0;
          end else begin
            dly <= dly + DW'(1);
          end
        end
        ST_MEAS: begin
          if (gnt_fall) begin
            if (req_ended) begin
              pass_o      <= (req_len_now == cnt_v[1]);
              width_err_o <= (req_len_now != cnt_v[1]);
              st          <= ST_IDLE;
            end else begin
              gnt_len <= cnt_v[1];
              st      <= ST_WAIT_R;
            end
          end
        end
        ST_WAIT_R: begin
          if (req_fall) begin
            pass_o      <= (cnt_v[0] == gnt_len);
            width_err_o <= (cnt_v[0] != gnt_len);
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rg_handshake_mon_chk.sv
module rg_handshake_mon_chk (
  input logic clk,
  input logic rst,
  input logic gnt_i,
  input logic pass_o,
  input logic width_err_o,
  input logic delay_err_o,
  input logic overlap_seen_o
);
  // R4: a verdict only follows a sample where grant was already low
  a_r4_verdict_after_grant_low: assert property (@(posedge clk) disable iff (rst)
    (pass_o || width_err_o) |-> $past(!gnt_i));

  // R5: pass and width error never together
  a_r5_verdict_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && width_err_o));

  // R7: overlap flag is sticky
  a_r7_overlap_sticky: assert property (@(posedge clk) disable iff (rst)
    overlap_seen_o |=> overlap_seen_o);

  // R10: verdict strobes last one cycle
  a_r10_pass_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pass_o |=> !pass_o);
  a_r10_werr_one_cycle: assert property (@(posedge clk) disable iff (rst)
    width_err_o |=> !width_err_o);

  // R9: first cycle after reset shows cleared outputs
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(pass_o || width_err_o || delay_err_o || overlap_seen_o));
endmodule

bind rg_handshake_mon rg_handshake_mon_chk u_chk (
  .clk(clk), .rst(rst), .gnt_i(gnt_i), .pass_o(pass_o),
  .width_err_o(width_err_o), .delay_err_o(delay_err_o),
  .overlap_seen_o(overlap_seen_o)
);

// File: tb/rg_handshake_mon_tb.sv
module rg_handshake_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic gnt = 1'b0;
  logic pass_o, width_err_o, delay_err_o, overlap_seen_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rg_handshake_mon #(.DELAY(DLY), .CNT_W(8)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .gnt_i(gnt),
    .pass_o(pass_o), .width_err_o(width_err_o),
    .delay_err_o(delay_err_o), .overlap_seen_o(overlap_seen_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive on falling edge, sample just after the rising edge.
  task automatic step(input logic r, input logic g);
    @(negedge clk);
    req = r;
    gnt = g;
    @(posedge clk);
    #1;
  endtask

  int pc, wc, dc, dbl;

  task automatic run_txn(input int w, input int g, input int d);
    int n;
    logic prev_p, prev_w;
    n = ((w > d + g) ? w : d + g) + 4;
    pc = 0; wc = 0; dc = 0; dbl = 0;
    prev_p = 1'b0; prev_w = 1'b0;
    for (int c = 0; c < n; c++) begin
      step(c < w, (c >= d) && (c < d + g));
      pc += int'(pass_o);
      wc += int'(width_err_o);
      dc += int'(delay_err_o);
      if ((prev_p && pass_o) || (prev_w && width_err_o)) dbl++;
      prev_p = pass_o;
      prev_w = width_err_o;
    end
  endtask

  initial begin
    // R9: outputs held clear during reset
    repeat (3) step(1'b0, 1'b0);
    chk("R9 reset outputs", int'({pass_o, width_err_o, delay_err_o, overlap_seen_o}), 0);
    @(negedge clk) rst = 1'b0;

    // Sweep: R1 R2 R3 R4 R5 R6 R10
    for (int d = 1; d <= 5; d++) begin
      for (int w = 1; w <= 6; w++) begin
        for (int g = 1; g <= 6; g++) begin
          int ep, ew, ed;
          string tp, td;
          run_txn(w, g, d);
          ep = (d == DLY && w == g) ? 1 : 0;
          ew = (d == DLY && w != g) ? 1 : 0;
          ed = (d < DLY) ? 1 : ((d > DLY) ? 2 : 0);
          if (d != DLY) tp = (d < DLY) ? "R1 early no verdict" : "R2 late no verdict";
          else if (w > DLY) tp = "R6 overlap verdict";
          else tp = (w == g) ? "R4 equal widths" : "R5 unequal widths";
          td = (d < DLY) ? "R1 early grant" : ((d > DLY) ? "R2 R3 late plus stray" : "R1 on-time grant");
          chk($sformatf("%s pass w=%0d g=%0d d=%0d", tp, w, g, d), pc, ep);
          chk($sformatf("%s werr w=%0d g=%0d d=%0d", tp, w, g, d), wc, ew);
          chk($sformatf("%s derr w=%0d g=%0d d=%0d", td, w, g, d), dc, ed);
          chk($sformatf("R10 strobe length w=%0d g=%0d d=%0d", w, g, d), dbl, 0);
        end
      end
    end

    // R8: saturation
    run_txn(300, 300, DLY);
    chk("R8 both saturated pass", pc, 1);
    chk("R8 both saturated werr", wc, 0);
    run_txn(254, 255, DLY);
    chk("R8 below limit werr", wc, 1);
    chk("R8 below limit pass", pc, 0);

    // R7: second request inside open handshake
    chk("R7 overlap clear before", int'(overlap_seen_o), 0);
    pc = 0; wc = 0;
    step(1'b1, 1'b0);  // cycle 0 request rises
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);  // cycle 2 ignored rise
    step(1'b0, 1'b1);  // cycle 3 grant rises
    step(1'b0, 1'b0);  // cycle 4 grant falls
    pc += int'(pass_o); wc += int'(width_err_o);
    step(1'b0, 1'b0);
    chk("R10 pass low next cycle", int'(pass_o), 0);
    repeat (3) step(1'b0, 1'b0);
    chk("R7 ignored rise keeps pass", pc, 1);
    chk("R7 ignored rise no werr", wc, 0);
    chk("R7 overlap sticky", int'(overlap_seen_o), 1);

    // R9: reset mid-handshake, then a stray grant
    @(negedge clk) rst = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R9 reset clears overlap", int'(overlap_seen_o), 0);
    @(negedge clk) rst = 1'b0;
    step(1'b1, 1'b0);
    @(negedge clk) rst = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk) rst = 1'b0;
    run_txn(0, 1, 1);
    chk("R9 abandoned handshake stray grant derr", dc, 1);
    chk("R9 abandoned handshake no pass", pc + wc, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule